// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a chain of register stages, eight by default, that either captures a whole word from parallel inputs or moves data one stage toward the far end, taking a new bit in from a serial input. Only the last stage is visible, as the serial output. The active-low `load_n` select picks between capture and shift. The active-low `run_n` enable allows either operation to happen on a rising clock edge. When it is high, the contents stay frozen.

The enable acts as a synchronous condition on flops that share a free-running clock. The clock itself is never gated, so no false edge can come from an enable that changes while the clock is high. An active-low asynchronous clear empties every stage at once and takes priority over everything else. Longer chains are formed by wiring `ser_out` of one instance to `ser_in` of the next.

Top module: `piso_chain_reg`

## Requirements
- R1: While `clear_n` is low, every stage is 0, so `ser_out` reads 0. This takes effect as soon as `clear_n` falls, with no clock edge needed.
- R2: On a rising edge with `run_n`=0 and `load_n`=0, stage i takes `par_in[i]`. Afterwards `ser_out` equals `par_in[WIDTH-1]`, and `ser_in` has no effect on that edge.
- R3: On a rising edge with `run_n`=0 and `load_n`=1, stage 0 takes `ser_in` and stage i takes the old stage i-1. A loaded word therefore leaves on `ser_out` highest bit first, one bit per enabled edge.
- R4: On a rising edge with `run_n`=1, all stages keep their values, whatever `load_n`, `ser_in` and `par_in` carry.
- R5: A clear that is held across a rising edge wins over a load or a shift requested on that edge.
- R6: After `clear_n` is released, the first rising edge with `run_n`=0 performs an ordinary load or shift.
- R7: A bit presented on `ser_in` at an enabled shift edge reaches `ser_out` after exactly WIDTH enabled shift edges, and not after WIDTH-1.
- R8: A load requested in the middle of a shift-out discards the rest of the old word. The next `ser_out` value is the top bit of the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock, rising edge active |
| clear_n | input | 1 | Asynchronous clear of all stages, active low |
| load_n | input | 1 | 0 selects parallel capture, 1 selects shift |
| run_n | input | 1 | 0 lets the selected operation happen on the edge, 1 freezes the stages |
| ser_in | input | 1 | Bit entering stage 0 on a shift |
| par_in | input | WIDTH | Word captured on a load, bit i into stage i |
| ser_out | output | 1 | Value of the last stage |

## Verification
Two pairs of functions can fall in the same cycle.

- **Clear and load/shift.** The bench drops `clear_n` halfway between edges while a load is pending, and holds it low across an edge that requests a load of all ones. `ser_out` is judged 0 both before that edge and after it. The first operation after release is then judged against the reference model.
- **Load and shift.** The vector table and a directed test request a reload while a shift-out is in progress. The output is judged to jump to the new word's top bit at once.

Every step is also compared against a bit-queue model of the chain.

// File: rtl/piso_pkg.sv
package piso_pkg;

   // Operation applied to every stage on a rising clock edge
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_SHIFT = 2'd2
   } stage_op_e;

   // Enable is checked first: a frozen chain ignores the select entirely
   function automatic stage_op_e pick_op(input logic run_n, input logic load_n);
      stage_op_e op;
      if (run_n)
         op = OP_HOLD;
      else if (!load_n)
         op = OP_LOAD;
      else
         op = OP_SHIFT;
      return op;
   endfunction

endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
   import piso_pkg::*;
(
   input  logic      run_n,
   input  logic      load_n,
   output stage_op_e op
);

   always_comb begin
      op = pick_op(run_n, load_n);
   end

endmodule

// File: rtl/piso_stage.sv
module piso_stage
   import piso_pkg::*;
(
   input  logic      clk,
   input  logic      clear_n,
   input  stage_op_e op,
   input  logic      par_bit,
   input  logic      shift_bit,
   output logic      q
);

   logic nxt;

   always_comb begin
      unique case (op)
         OP_LOAD:  nxt = par_bit;
         OP_SHIFT: nxt = shift_bit;
         default:  nxt = q;
      endcase
   end

   always_ff @(posedge clk or negedge clear_n) begin
      if (!clear_n)
         q <= 1'b0;
      else
         q <= nxt;
   end

endmodule

// File: rtl/piso_chain_reg.sv
module piso_chain_reg
   import piso_pkg::*;
#(
   parameter int WIDTH = 8
)(
   input  logic             clk,
   input  logic             clear_n,
   input  logic             load_n,
   input  logic             run_n,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   output logic             ser_out
);

   localparam int LAST = WIDTH - 1;

   // Elaboration-time parameter check
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("piso_chain_reg: WIDTH must be at least 2");
      end
   endgenerate

   stage_op_e        op;
   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] shift_src;

   piso_ctrl u_ctrl (
      .run_n  (run_n),
      .load_n (load_n),
      .op     (op)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign shift_src[i] = ser_in;
         end else begin : g_body
            assign shift_src[i] = q[i-1];
         end

         piso_stage u_stage (
            .clk       (clk),
            .clear_n   (clear_n),
            .op        (op),
            .par_bit   (par_in[i]),
            .shift_bit (shift_src[i]),
            .q         (q[i])
         );
      end
   endgenerate

   assign ser_out = q[LAST];

   // R1/R6: at the first edge after release the chain is still empty
   assert_release_empty_R1: assert property (@(posedge clk) disable iff (!clear_n)
      $rose(clear_n) |-> (q == '0));

   // R2: an enabled load captures the parallel word
   assert_load_word_R2: assert property (@(posedge clk) disable iff (!clear_n)
      (!run_n && !load_n) |=> (q == $past(par_in)));

   // R3: an enabled shift moves every stage up by one
   assert_shift_step_R3: assert property (@(posedge clk) disable iff (!clear_n)
      (!run_n && load_n) |=> (q == {$past(q[LAST-1:0]), $past(ser_in)}));

   // R4: a frozen chain keeps its contents
   assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (!clear_n)
      run_n |=> $stable(q));

endmodule

// File: tb/piso_chain_reg_bench.sv
module piso_chain_reg_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int NVEC       = 16;

   // Vector: [11] expected ser_out after edge, [10] run_n, [9] load_n,
   //         [8] ser_in, [7:0] par_in. Starts from an empty chain.
   localparam logic [11:0] VEC [NVEC] = '{
      12'h9A5, 12'h200, 12'hB00, 12'hDFF, 12'h3AA, 12'h255, 12'h03C, 12'h2FF,
      12'hA00, 12'hE00, 12'hB00, 12'hB00, 12'hA00, 12'h200, 12'h880, 12'h300
   };

   logic         clk = 1'b0;
   logic         clear_n;
   logic         load_n;
   logic         run_n;
   logic         ser_in;
   logic [W-1:0] par_in;
   logic         ser_out;

   int  n_cmp  = 0;
   int  n_bad  = 0;
   bit  done   = 1'b0;
   bit  mq[$];

   piso_chain_reg #(.WIDTH(W)) u_piso_chain_reg (
      .clk     (clk),
      .clear_n (clear_n),
      .load_n  (load_n),
      .run_n   (run_n),
      .ser_in  (ser_in),
      .par_in  (par_in),
      .ser_out (ser_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: ser_out=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      mq.delete();
      for (int i = 0; i < W; i++) mq.push_back(1'b0);
   endtask

   task automatic model_edge(input logic rn, input logic ln, input logic si,
                             input logic [W-1:0] p);
      if (!rn) begin
         if (!ln) begin
            for (int i = 0; i < W; i++) mq[i] = p[i];
         end else begin
            mq.push_front(si);
            void'(mq.pop_back());
         end
      end
   endtask

   // Drive at the falling edge, apply one rising edge, settle after it
   task automatic step(input logic rn, input logic ln, input logic si,
                       input logic [W-1:0] p);
      @(negedge clk);
      run_n = rn; load_n = ln; ser_in = si; par_in = p;
      @(posedge clk);
      model_edge(rn, ln, si, p);
      #1;
   endtask

   task automatic do_clear();
      @(negedge clk);
      clear_n = 1'b0;
      model_clear();
      @(negedge clk);
      clear_n = 1'b1;
   endtask

   initial begin
      clear_n = 1'b0; load_n = 1'b1; run_n = 1'b1; ser_in = 1'b0; par_in = '0;
      model_clear();
      repeat (2) @(negedge clk);
      #1;
      check("R1 reset state", ser_out, 1'b0);
      clear_n = 1'b1;

      // Table walk: load, shift, hold and mid-shift reload
      for (int v = 0; v < NVEC; v++) begin
         step(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0]);
         if (!VEC[v][10] && !VEC[v][9])
            check("R2/R8 table load", ser_out, VEC[v][11]);
         else if (VEC[v][10])
            check("R4 table hold", ser_out, VEC[v][11]);
         else
            check("R3 table shift", ser_out, VEC[v][11]);
         check("R3 table vs queue model", ser_out, mq[W-1]);
      end

      // R3: eight-cycle shift-out of a loaded byte, every bit checked
      do_clear();
      step(1'b0, 1'b0, 1'b0, 8'h6B);
      check("R3 shift-out bit 7", ser_out, 1'b0);
      for (int k = 1; k < W; k++) begin
         step(1'b0, 1'b1, 1'b0, 8'hFF);
         check("R3 shift-out", ser_out, mq[W-1]);
         check("R3 shift-out word bit", ser_out, (8'h6B >> (W-1-k)) & 1'b1);
      end

      // R2: serial input ignored during a load
      step(1'b0, 1'b0, 1'b1, 8'h00);
      for (int k = 0; k < W; k++) begin
         step(1'b0, 1'b1, 1'b0, 8'hFF);
         check("R2 ser_in ignored on load", ser_out, 1'b0);
      end

      // R4: several frozen edges with busy inputs
      step(1'b0, 1'b0, 1'b0, 8'h80);
      for (int k = 0; k < 4; k++) begin
         step(1'b1, k[0], ~k[0], 8'h00);
         check("R4 frozen", ser_out, 1'b1);
      end

      // R7: one bit crosses the chain in exactly W shifts
      do_clear();
      step(1'b0, 1'b1, 1'b1, 8'h00);
      for (int k = 2; k <= W; k++) begin
         step(1'b0, 1'b1, 1'b0, 8'h00);
         check("R7 cascade timing", ser_out, (k == W) ? 1'b1 : 1'b0);
      end

      // R8: reload in the middle of a shift-out
      step(1'b0, 1'b0, 1'b0, 8'hF0);
      step(1'b0, 1'b1, 1'b0, 8'h00);
      step(1'b0, 1'b1, 1'b0, 8'h00);
      step(1'b0, 1'b0, 1'b1, 8'h40);
      check("R8 reload replaces word", ser_out, 1'b0);
      step(1'b0, 1'b1, 1'b0, 8'h00);
      check("R8 reload next bit", ser_out, 1'b1);

      // R1/R5/R6: clear between edges, held across an enabled load
      step(1'b0, 1'b0, 1'b0, 8'hFF);
      check("R2 load all ones", ser_out, 1'b1);
      #(CLK_PERIOD/4);
      clear_n = 1'b0;
      model_clear();
      #1;
      check("R1 async clear without edge", ser_out, 1'b0);
      step(1'b0, 1'b0, 1'b1, 8'hFF);
      model_clear();
      check("R5 clear beats load", ser_out, 1'b0);
      #(CLK_PERIOD/4);
      clear_n = 1'b1;
      step(1'b0, 1'b0, 1'b0, 8'h80);
      check("R6 first op after release", ser_out, 1'b1);
      step(1'b0, 1'b1, 1'b0, 8'h00);
      check("R6 shift after release", ser_out, mq[W-1]);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule